// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits beside an EEPROM page controller and watches every byte write event on its way in. It spots two fixed address/data key sequences (a three-byte one that turns protection on and a six-byte one that turns it off) and, for each write, tells the controller whether the byte is a key byte or a data byte. For a data byte it also says whether the byte may be committed to the array.

Protection is held as one bit per 32 KB block. Each bit changes only when the controller signals that the current programming cycle has finished. The bits start cleared and survive reset, which stands in for non-volatile storage. While a block is protected, a page load is committed only when the three-byte enable prefix was written just before it. A load without the prefix still opens a programming cycle, but its bytes are suppressed.

Top module: `wp_seq`

## Requirements
- R1: The key writes AA to 5555, then 55 to 2AAA, then A0 to 5555 (hex, address bits [14:0], data bits [7:0]) sets the protection bit of the block given with the final key write, at the next `prog_done` pulse.
- R2: The key writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 clears the protection bit of the block given with the final key write, at the next `prog_done` pulse.
- R3: Each write that matches the expected next key step is flagged on `wr_key` in the same cycle, and `wr_commit` stays low for it.
- R4: A data write to a protected block has `wr_commit` low unless a complete key sequence opened the current programming cycle.
- R5: Data writes that follow a completed key sequence, up to the next `prog_done`, are committed even to a protected block.
- R6: A data write to an unprotected block has `wr_commit` high.
- R7: A completed sequence takes effect at `prog_done` even when no data byte follows it, and `prot_status` changes at no other time.
- R8: `prot_status` bit i is block i. All bits are clear from power-up, and each block's bit changes independently of the others.
- R9: Reset leaves `prot_status` unchanged and drops any partly matched sequence, so the next write is matched from the first key step.
- R10: A write that does not match the expected key step aborts matching and is an ordinary data write, and it opens a programming cycle.
- R11: Once a programming cycle is open (after a data write or a completed sequence), every write up to `prog_done` is a data write and no key matching takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the sequence and cycle state |
| wr_valid | input | 1 | A byte write event is present this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wr_blk | input | BLK_W | 32 KB block addressed by the write |
| prog_done | input | 1 | One-cycle pulse at the end of a programming cycle |
| wr_key | output | 1 | The current write is a key byte and is not stored |
| wr_commit | output | 1 | The current data write may be committed |
| prot_status | output | NUM_BLK | Protection bit per block |

## Verification
A sequence matcher stuck in the wrong step shows up at once, on the next write: `wr_key` is wrong for that write, or the write that should finish a sequence passes as data. A lost or misdirected pending action is only visible one cycle after the next `prog_done`, where `prot_status` holds the wrong bit pattern. A stale authorisation flag shows up on the first data write to a protected block in the following cycle, where `wr_commit` has the wrong value.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  // Key comparison always uses the low 15 address bits and one data byte.
  localparam int KEY_AW = 15;
  localparam int KEY_DW = 8;

  localparam logic [KEY_AW-1:0] ADR_HI = 15'h5555;
  localparam logic [KEY_AW-1:0] ADR_LO = 15'h2AAA;

  localparam logic [KEY_DW-1:0] KD_LEAD  = 8'hAA;
  localparam logic [KEY_DW-1:0] KD_SECND = 8'h55;
  localparam logic [KEY_DW-1:0] KD_LOCK  = 8'hA0;
  localparam logic [KEY_DW-1:0] KD_EXT   = 8'h80;
  localparam logic [KEY_DW-1:0] KD_OPEN  = 8'h20;

  // Matcher progress: which key step is expected next.
  typedef enum logic [2:0] {
    M_IDLE,
    M_STEP1,
    M_STEP2,
    M_EXT1,
    M_EXT2,
    M_EXT3
  } mstate_e;

  function automatic logic key_is(input logic [KEY_AW-1:0] a,
                                  input logic [KEY_DW-1:0] d,
                                  input logic [KEY_AW-1:0] ka,
                                  input logic [KEY_DW-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  // A data write passes when the block is open or the cycle is authorised.
  function automatic logic commit_ok(input logic valid, input logic is_key,
                                     input logic auth, input logic blk_prot);
    return valid && !is_key && (auth || !blk_prot);
  endfunction

endpackage

// File: rtl/wp_key_matcher.sv
module wp_key_matcher
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_DW-1:0] data,
  output logic              is_key,
  output logic              en_done,
  output logic              dis_done
);

  mstate_e           st_q, st_d;
  logic [KEY_AW-1:0] a15;

  assign a15 = addr[KEY_AW-1:0];

  always_comb begin
    st_d     = st_q;
    is_key   = 1'b0;
    en_done  = 1'b0;
    dis_done = 1'b0;
    if (ev) begin
      st_d = M_IDLE;
      unique case (st_q)
        M_IDLE: if (key_is(a15, data, ADR_HI, KD_LEAD)) begin
          is_key = 1'b1; st_d = M_STEP1;
        end
        M_STEP1: if (key_is(a15, data, ADR_LO, KD_SECND)) begin
          is_key = 1'b1; st_d = M_STEP2;
        end
        M_STEP2: if (key_is(a15, data, ADR_HI, KD_LOCK)) begin
          is_key = 1'b1; en_done = 1'b1;
        end else if (key_is(a15, data, ADR_HI, KD_EXT)) begin
          is_key = 1'b1; st_d = M_EXT1;
        end
        M_EXT1: if (key_is(a15, data, ADR_HI, KD_LEAD)) begin
          is_key = 1'b1; st_d = M_EXT2;
        end
        M_EXT2: if (key_is(a15, data, ADR_LO, KD_SECND)) begin
          is_key = 1'b1; st_d = M_EXT3;
        end
        M_EXT3: if (key_is(a15, data, ADR_HI, KD_OPEN)) begin
          is_key = 1'b1; dis_done = 1'b1;
        end
        default: st_d = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= M_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/wp_cycle_trk.sv
module wp_cycle_trk #(
  parameter int BLK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_done,
  input  logic             wr_evt,
  input  logic             is_key,
  input  logic             en_done,
  input  logic             dis_done,
  input  logic [BLK_W-1:0] blk,
  output logic             open_q,
  output logic             auth_q,
  output logic             apply_v,
  output logic             apply_en,
  output logic [BLK_W-1:0] apply_blk
);

  logic             pend_v;
  logic             pend_en;
  logic [BLK_W-1:0] pend_blk;

  // The pending action is handed to the store when the cycle ends.
  assign apply_v   = prog_done && pend_v;
  assign apply_en  = pend_en;
  assign apply_blk = pend_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      auth_q   <= 1'b0;
      pend_v   <= 1'b0;
      pend_en  <= 1'b0;
      pend_blk <= '0;
    end else begin
      if (prog_done) begin
        open_q <= 1'b0;
        auth_q <= 1'b0;
        pend_v <= 1'b0;
      end
      if (wr_evt) begin
        if (en_done || dis_done) begin
          open_q   <= 1'b1;
          auth_q   <= 1'b1;
          pend_v   <= 1'b1;
          pend_en  <= en_done;
          pend_blk <= blk;
        end else if (!is_key) begin
          open_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wp_prot_bank.sv
module wp_prot_bank #(
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2
) (
  input  logic               clk,
  input  logic               apply_v,
  input  logic               apply_en,
  input  logic [BLK_W-1:0]   apply_blk,
  output logic [NUM_BLK-1:0] prot
);

  // No reset: these bits model non-volatile cells, clear when delivered.
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic bit_q = 1'b0;
    always_ff @(posedge clk) begin
      if (apply_v && (apply_blk == BLK_W'(i))) bit_q <= apply_en;
    end
    assign prot[i] = bit_q;
  end

endmodule

// File: rtl/wp_seq.sv
module wp_seq
  import wp_seq_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int ADDR_W  = 15,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [BLK_W-1:0]   wr_blk,
  input  logic               prog_done,
  output logic               wr_key,
  output logic               wr_commit,
  output logic [NUM_BLK-1:0] prot_status
);

  // Named internal events, used by the bound checker.
  logic             match_ev;
  logic             seq_en_done;
  logic             seq_dis_done;
  logic             cyc_open;
  logic             seq_auth;
  logic             apply_v;
  logic             apply_en;
  logic [BLK_W-1:0] apply_blk;
  logic             blk_prot;

  // Matching only runs while no programming cycle is open.
  assign match_ev = wr_valid && !cyc_open;

  wp_key_matcher #(.ADDR_W(ADDR_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (match_ev),
    .addr     (wr_addr),
    .data     (wr_data),
    .is_key   (wr_key),
    .en_done  (seq_en_done),
    .dis_done (seq_dis_done)
  );

  wp_cycle_trk #(.BLK_W(BLK_W)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_done (prog_done),
    .wr_evt    (wr_valid),
    .is_key    (wr_key),
    .en_done   (seq_en_done),
    .dis_done  (seq_dis_done),
    .blk       (wr_blk),
    .open_q    (cyc_open),
    .auth_q    (seq_auth),
    .apply_v   (apply_v),
    .apply_en  (apply_en),
    .apply_blk (apply_blk)
  );

  wp_prot_bank #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_bank (
    .clk       (clk),
    .apply_v   (apply_v),
    .apply_en  (apply_en),
    .apply_blk (apply_blk),
    .prot      (prot_status)
  );

  // Out-of-range block numbers are treated as protected.
  assign blk_prot  = (int'(wr_blk) < NUM_BLK) ? prot_status[wr_blk] : 1'b1;
  assign wr_commit = commit_ok(wr_valid, wr_key, seq_auth, blk_prot);

endmodule

// File: rtl/wp_seq_chk.sv
module wp_seq_chk #(
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic [BLK_W-1:0]   wr_blk,
  input logic               prog_done,
  input logic               wr_key,
  input logic               wr_commit,
  input logic [NUM_BLK-1:0] prot_status,
  input logic               cyc_open,
  input logic               seq_auth,
  input logic               seq_en_done,
  input logic               seq_dis_done
);

  // R3: a key byte is never committed
  a_r3_key_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_key |-> !wr_commit);

  // R7: protection bits move only after a cycle-done pulse
  a_r7_prot_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(prot_status));

  // R6: data to an unprotected block passes
  a_r6_open_block_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_key && !prot_status[wr_blk]) |-> wr_commit);

  // R4: a commit into a protected block needs an authorised cycle
  a_r4_prot_needs_auth: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && prot_status[wr_blk]) |-> seq_auth);

  // R11: no key matching inside an open cycle
  a_r11_open_no_key: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_open |-> !wr_key);

  // R1: enable and disable completions never coincide
  a_r1_single_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_en_done, seq_dis_done}));

  // R5: a completed sequence leaves the next cycle authorised
  a_r5_auth_after_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (seq_en_done || seq_dis_done) && !prog_done) |=> (seq_auth && cyc_open));

endmodule

bind wp_seq wp_seq_chk #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_blk       (wr_blk),
  .prog_done    (prog_done),
  .wr_key       (wr_key),
  .wr_commit    (wr_commit),
  .prot_status  (prot_status),
  .cyc_open     (cyc_open),
  .seq_auth     (seq_auth),
  .seq_en_done  (seq_en_done),
  .seq_dis_done (seq_dis_done)
);

// File: tb/tb_wp_seq.sv
module tb_wp_seq;

  localparam int NB = 4;
  localparam int BW = 2;
  localparam int NV = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [14:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [BW-1:0] wr_blk = '0;
  logic          prog_done = 1'b0;
  logic          wr_key;
  logic          wr_commit;
  logic [NB-1:0] prot_status;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wp_seq #(.NUM_BLK(NB), .ADDR_W(15)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_blk(wr_blk), .prog_done(prog_done),
    .wr_key(wr_key), .wr_commit(wr_commit), .prot_status(prot_status)
  );

  // Vector: {valid, done, addr, data, blk, exp_key, exp_commit, exp_prot}
  typedef struct packed {
    logic        v;
    logic        d;
    logic [14:0] a;
    logic [7:0]  dt;
    logic [1:0]  b;
    logic        k;
    logic        c;
    logic [3:0]  p;
  } vec_t;

  localparam logic [32:0] VT [0:NV-1] = '{
    {1'b1,1'b0,15'h1234,8'h11,2'd0,1'b0,1'b1,4'b0000}, // 0  R6 R8 plain write
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0000}, // 1
    {1'b1,1'b0,15'h5555,8'hAA,2'd1,1'b1,1'b0,4'b0000}, // 2  R1 R3 key
    {1'b1,1'b0,15'h2AAA,8'h55,2'd1,1'b1,1'b0,4'b0000}, // 3
    {1'b1,1'b0,15'h5555,8'hA0,2'd1,1'b1,1'b0,4'b0000}, // 4
    {1'b1,1'b0,15'h0100,8'h5A,2'd1,1'b0,1'b1,4'b0000}, // 5  R5
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0000}, // 6  R7 not yet
    {1'b1,1'b0,15'h0200,8'h33,2'd1,1'b0,1'b0,4'b0010}, // 7  R1 R4 suppressed
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0010}, // 8
    {1'b1,1'b0,15'h0300,8'h44,2'd0,1'b0,1'b1,4'b0010}, // 9  R8 other block
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0010}, // 10
    {1'b1,1'b0,15'h5555,8'hAA,2'd1,1'b1,1'b0,4'b0010}, // 11 R5 prefix
    {1'b1,1'b0,15'h2AAA,8'h55,2'd1,1'b1,1'b0,4'b0010}, // 12
    {1'b1,1'b0,15'h5555,8'hA0,2'd1,1'b1,1'b0,4'b0010}, // 13
    {1'b1,1'b0,15'h0140,8'h66,2'd1,1'b0,1'b1,4'b0010}, // 14 R5 protected passes
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0010}, // 15
    {1'b1,1'b0,15'h5555,8'hAA,2'd2,1'b1,1'b0,4'b0010}, // 16 R10
    {1'b1,1'b0,15'h2AAA,8'h55,2'd2,1'b1,1'b0,4'b0010}, // 17
    {1'b1,1'b0,15'h5555,8'h7E,2'd2,1'b0,1'b1,4'b0010}, // 18 R10 breaker is data
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0010}, // 19
    {1'b1,1'b0,15'h5555,8'hAA,2'd1,1'b1,1'b0,4'b0010}, // 20 R2
    {1'b1,1'b0,15'h2AAA,8'h55,2'd1,1'b1,1'b0,4'b0010}, // 21
    {1'b1,1'b0,15'h5555,8'h80,2'd1,1'b1,1'b0,4'b0010}, // 22
    {1'b1,1'b0,15'h5555,8'hAA,2'd1,1'b1,1'b0,4'b0010}, // 23
    {1'b1,1'b0,15'h2AAA,8'h55,2'd1,1'b1,1'b0,4'b0010}, // 24
    {1'b1,1'b0,15'h5555,8'h20,2'd1,1'b1,1'b0,4'b0010}, // 25
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0010}, // 26 R7 no data
    {1'b1,1'b0,15'h0500,8'h77,2'd1,1'b0,1'b1,4'b0000}, // 27 R2 cleared
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0000}, // 28
    {1'b1,1'b0,15'h5555,8'hAA,2'd3,1'b1,1'b0,4'b0000}, // 29 R7 enable, no data
    {1'b1,1'b0,15'h2AAA,8'h55,2'd3,1'b1,1'b0,4'b0000}, // 30
    {1'b1,1'b0,15'h5555,8'hA0,2'd3,1'b1,1'b0,4'b0000}, // 31
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b0000}, // 32
    {1'b1,1'b0,15'h6000,8'h88,2'd3,1'b0,1'b0,4'b1000}, // 33 R4 R7
    {1'b1,1'b0,15'h5555,8'hAA,2'd0,1'b0,1'b1,4'b1000}, // 34 R11 open cycle
    {1'b0,1'b1,15'h0000,8'h00,2'd0,1'b0,1'b0,4'b1000}  // 35
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic d, input logic [14:0] a,
                       input logic [7:0] dt, input logic [1:0] b);
    @(negedge clk);
    wr_valid = v; prog_done = d; wr_addr = a; wr_data = dt; wr_blk = b;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 15'h0, 8'h0, 2'd0);
  endtask

  task automatic wr_seq3(input logic [1:0] b);
    drive(1'b1, 1'b0, 15'h5555, 8'hAA, b);
    drive(1'b1, 1'b0, 15'h2AAA, 8'h55, b);
    drive(1'b1, 1'b0, 15'h5555, 8'hA0, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state, all protection clear
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset prot_status", 32'(prot_status), 32'h0);
    chk("R8 reset wr_key", 32'(wr_key), 32'h0);
    chk("R8 reset wr_commit", 32'(wr_commit), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t e;
      e = vec_t'(VT[i]);
      drive(e.v, e.d, e.a, e.dt, e.b);
      chk($sformatf("vec%0d key", i), 32'(wr_key), 32'(e.k));
      chk($sformatf("vec%0d commit", i), 32'(wr_commit), 32'(e.c));
      chk($sformatf("vec%0d prot", i), 32'(prot_status), 32'(e.p));
    end
    idle();

    // R9: reset mid-sequence keeps protection, drops sequence progress
    drive(1'b1, 1'b0, 15'h5555, 8'hAA, 2'd0);
    drive(1'b1, 1'b0, 15'h2AAA, 8'h55, 2'd0);
    chk("R9 partial key", 32'(wr_key), 32'h1);
    idle();
    rst_n = 1'b0;
    idle();
    idle();
    chk("R9 prot kept over reset", 32'(prot_status), 32'h8);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 15'h5555, 8'hA0, 2'd0);
    chk("R9 step after reset is data", 32'(wr_key), 32'h0);
    chk("R9 data commits", 32'(wr_commit), 32'h1);
    drive(1'b0, 1'b1, 15'h0, 8'h0, 2'd0);
    idle();
    chk("R9 prot unchanged", 32'(prot_status), 32'h8);

    // R5: full prefix then data into protected block 3
    wr_seq3(2'd3);
    drive(1'b1, 1'b0, 15'h6010, 8'h99, 2'd3);
    chk("R5 prefixed data commits", 32'(wr_commit), 32'h1);
    drive(1'b1, 1'b0, 15'h6011, 8'h9A, 2'd3);
    chk("R5 second page byte commits", 32'(wr_commit), 32'h1);
    drive(1'b0, 1'b1, 15'h0, 8'h0, 2'd0);
    idle();
    chk("R1 re-enable keeps bit", 32'(prot_status), 32'h8);

    // R10: break in the long sequence after four steps
    drive(1'b1, 1'b0, 15'h5555, 8'hAA, 2'd3);
    drive(1'b1, 1'b0, 15'h2AAA, 8'h55, 2'd3);
    drive(1'b1, 1'b0, 15'h5555, 8'h80, 2'd3);
    drive(1'b1, 1'b0, 15'h5555, 8'hAA, 2'd3);
    chk("R3 fourth key step", 32'(wr_key), 32'h1);
    drive(1'b1, 1'b0, 15'h0000, 8'h12, 2'd3);
    chk("R10 breaker not key", 32'(wr_key), 32'h0);
    chk("R4 breaker to protected suppressed", 32'(wr_commit), 32'h0);
    drive(1'b0, 1'b1, 15'h0, 8'h0, 2'd0);
    idle();
    chk("R10 aborted disable no effect", 32'(prot_status), 32'h8);

    // R8: two blocks protected at once, independent bits
    wr_seq3(2'd0);
    drive(1'b0, 1'b1, 15'h0, 8'h0, 2'd0);
    idle();
    chk("R8 blocks 0 and 3", 32'(prot_status), 32'h9);
    drive(1'b1, 1'b0, 15'h0001, 8'h01, 2'd2);
    chk("R6 block 2 still open", 32'(wr_commit), 32'h1);
    drive(1'b0, 1'b1, 15'h0, 8'h0, 2'd0);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule